// File: doc/BRIEF.md
# Sampling Converter Readout Sequencer

This block sits on the host side of an external 18-bit sampling converter. When `go` is seen in idle, it sends a one-cycle conversion-start pulse and follows the converter's busy flag through the conversion. It then collects a result over one of two paths, chosen per transaction. The serial path clocks in 18 bits. The byte path reads two bytes from an 8-bit tri-state bus.

Two read timings are offered. In late mode, the read waits until busy falls and returns the value just converted. In early mode, the read starts as soon as busy rises and returns the result of the previous conversion. An early read must finish inside the first half of the busy interval, and that interval is given by a programmable conversion length. A read that cannot finish in time is cut off and reported as an overrun. Each completed read is presented with a one-cycle valid pulse.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, `cnvst`, `sclk`, `result_valid` and `overrun` are 0, and `cs_n` and `rd_n` are 1.
- R2: `go` sampled high in idle makes `cnvst` high for exactly one cycle, starting with the cycle after the sampling edge.
- R3: `rd_n` is low only while `cs_n` is low. Both are high whenever no read is in progress, so the converter bus stays released.
- R4: The serial path gives exactly 18 `sclk` pulses, and each half period lasts `sclk_div`+1 clock cycles. The first bit is the most significant bit. `sclk` stays low while `cs_n` is high.
- R5: The serial path takes each bit on the rising edge of `sclk` when `sample_rise`=1, and on the falling edge when it is 0. Both settings return the same word.
- R6: The byte path makes two reads. The first has `byte_lo`=0 and returns word bits 17:10. The second has `byte_lo`=1 and returns bits 9:2. The result is {first byte, second byte, 2'b00}.
- R7: With `read_early`=0, the read starts after busy falls, and the result is the value of the conversion just finished.
- R8: With `read_early`=1, the read starts after busy rises, and the result is the value from the previous conversion.
- R9: In an early read, no new `sclk` rise and no new `rd_n` fall occur once `conv_len`/2 cycles have passed since busy rose. An unfinished read is then abandoned with a one-cycle `overrun` pulse and no `result_valid`.
- R10: `result_valid` is a one-cycle pulse carrying the assembled word on `result`. It never coincides with `overrun`.
- R11: No new `cnvst` is issued until the current read has ended and, in early mode, busy has fallen. A `go` held high therefore starts exactly one conversion per completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request one conversion-and-read transaction |
| use_serial | input | 1 | 1 selects the serial path, 0 the byte path |
| read_early | input | 1 | 1 reads the previous result during the conversion |
| sample_rise | input | 1 | Serial sampling edge: 1 rising, 0 falling |
| sclk_div | input | DIV_W (8) | Serial clock half period minus one, in clock cycles |
| conv_len | input | CNT_W (16) | Busy interval length in cycles, used for the early-read deadline |
| busy | input | 1 | Converter busy flag |
| par_data | input | BYTE_W (8) | Converter byte bus |
| sdata | input | 1 | Converter serial data |
| cnvst | output | 1 | Conversion-start pulse |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| byte_lo | output | 1 | Byte select: 0 high byte, 1 low byte |
| sclk | output | 1 | Serial data clock |
| result | output | DATA_W (18) | Assembled result word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |
| overrun | output | 1 | One-cycle flag for a missed early-read deadline |

## Verification
`cnvst` goes high on the edge that samples `go`. The bench therefore checks it at the next falling clock edge, and checks at the falling edge after that that it has dropped. The completion time of a read depends on the converter's busy timing and on `sclk_div`, so the bench watches each falling edge for `result_valid` or `overrun`, with a bounded cycle budget. It compares the word on the cycle the strobe appears and confirms the strobe is gone one cycle later. The idle levels of the bus controls are checked only after the modelled busy flag has dropped and `cs_n` has returned high.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_WAIT_RISE,
      ST_WAIT_FALL,
      ST_READ,
      ST_DRAIN
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_HIGH,
      PH_GAP,
      PH_LOW
   } byte_phase_t;
endpackage

// File: rtl/adc_rd_serial.sv
module adc_rd_serial #(
   parameter int DATA_W = 18,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              sample_rise,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              sdata,
   output logic              sclk,
   output logic              done,
   output logic [DATA_W-1:0] word
);
   localparam int CW = $clog2(DATA_W + 1);

   logic             active;
   logic [DIV_W-1:0] dcnt;
   logic [CW-1:0]    falls;

   logic tick, rise_now, fall_now, take;
   assign tick     = active && (dcnt == half_div);
   assign rise_now = tick && !sclk;
   assign fall_now = tick && sclk;
   assign take     = sample_rise ? rise_now : fall_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         dcnt   <= '0;
         falls  <= '0;
         sclk   <= 1'b0;
         done   <= 1'b0;
         word   <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            dcnt   <= '0;
            falls  <= '0;
            sclk   <= 1'b0;
         end else if (abort) begin
            active <= 1'b0;
            sclk   <= 1'b0;
         end else if (active) begin
            if (tick) begin
               dcnt <= '0;
               sclk <= ~sclk;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
            if (take)
               word <= {word[DATA_W-2:0], sdata};
            if (fall_now) begin
               falls <= falls + 1'b1;
               if (falls == CW'(DATA_W - 1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/adc_rd_bytes.sv
module adc_rd_bytes
   import adc_rd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int HOLD   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [BYTE_W-1:0] bus,
   output logic              rd_n,
   output logic              byte_lo,
   output logic              done,
   output logic [BYTE_W-1:0] hi_byte,
   output logic [BYTE_W-1:0] lo_byte
);
   localparam int HW = $clog2(HOLD + 1);

   byte_phase_t phase;
   logic [HW-1:0] cnt;
   logic          hold_end;
   assign hold_end = (cnt == HW'(HOLD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         rd_n    <= 1'b1;
         byte_lo <= 1'b0;
         done    <= 1'b0;
         hi_byte <= '0;
         lo_byte <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            phase   <= PH_HIGH;
            cnt     <= '0;
            rd_n    <= 1'b0;
            byte_lo <= 1'b0;
         end else if (abort) begin
            phase   <= PH_IDLE;
            rd_n    <= 1'b1;
            byte_lo <= 1'b0;
         end else begin
            case (phase)
               PH_HIGH: begin
                  if (hold_end) begin
                     hi_byte <= bus;
                     rd_n    <= 1'b1;
                     byte_lo <= 1'b1;
                     cnt     <= '0;
                     phase   <= PH_GAP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_GAP: begin
                  rd_n  <= 1'b0;
                  phase <= PH_LOW;
               end
               PH_LOW: begin
                  if (hold_end) begin
                     lo_byte <= bus;
                     rd_n    <= 1'b1;
                     byte_lo <= 1'b0;
                     done    <= 1'b1;
                     phase   <= PH_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/adc_rd_deadline.sv
module adc_rd_deadline #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] conv_len,
   output logic             late
);
   logic [CNT_W-1:0] elapsed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         elapsed <= '0;
      else if (clear)
         elapsed <= '0;
      else if (run && (elapsed != {CNT_W{1'b1}}))
         elapsed <= elapsed + 1'b1;
   end

   assign late = (elapsed >= (conv_len >> 1));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
   import adc_rd_pkg::*;
#(
   parameter int DATA_W  = 18,
   parameter int BYTE_W  = 8,
   parameter int DIV_W   = 8,
   parameter int CNT_W   = 16,
   parameter int RD_HOLD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              use_serial,
   input  logic              read_early,
   input  logic              sample_rise,
   input  logic [DIV_W-1:0]  sclk_div,
   input  logic [CNT_W-1:0]  conv_len,
   input  logic              busy,
   input  logic [BYTE_W-1:0] par_data,
   input  logic              sdata,
   output logic              cnvst,
   output logic              cs_n,
   output logic              rd_n,
   output logic              byte_lo,
   output logic              sclk,
   output logic [DATA_W-1:0] result,
   output logic              result_valid,
   output logic              overrun
);
   localparam int PAD_W = DATA_W - 2 * BYTE_W;

   generate
      if (PAD_W < 0) begin : g_bad_width
         $error("DATA_W must be at least two bytes wide");
      end
      if (RD_HOLD < 1) begin : g_bad_hold
         $error("RD_HOLD must be at least one cycle");
      end
      if (DIV_W < 1 || CNT_W < 2) begin : g_bad_counters
         $error("counter widths too small");
      end
   endgenerate

   seq_state_t state;
   logic early_q, serial_q, rise_q, rd_start;

   logic              s_done, b_done, late;
   logic [DATA_W-1:0] s_word, p_word;
   logic [BYTE_W-1:0] hi_b, lo_b;
   logic              rdr_done, deadline_hit;

   generate
      if (PAD_W == 0) begin : g_no_pad
         assign p_word = {hi_b, lo_b};
      end else begin : g_pad
         assign p_word = {hi_b, lo_b, {PAD_W{1'b0}}};
      end
   endgenerate

   assign rdr_done     = serial_q ? s_done : b_done;
   assign deadline_hit = (state == ST_READ) && early_q && late && !rdr_done;

   adc_rd_serial #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ser (
      .clk(clk), .rst_n(rst_n),
      .start(rd_start && serial_q), .abort(deadline_hit),
      .sample_rise(rise_q), .half_div(sclk_div), .sdata(sdata),
      .sclk(sclk), .done(s_done), .word(s_word)
   );

   adc_rd_bytes #(.BYTE_W(BYTE_W), .HOLD(RD_HOLD)) u_byt (
      .clk(clk), .rst_n(rst_n),
      .start(rd_start && !serial_q), .abort(deadline_hit),
      .bus(par_data), .rd_n(rd_n), .byte_lo(byte_lo), .done(b_done),
      .hi_byte(hi_b), .lo_byte(lo_b)
   );

   adc_rd_deadline #(.CNT_W(CNT_W)) u_dl (
      .clk(clk), .rst_n(rst_n),
      .clear(state == ST_WAIT_RISE), .run(state == ST_READ),
      .conv_len(conv_len), .late(late)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         early_q      <= 1'b0;
         serial_q     <= 1'b0;
         rise_q       <= 1'b0;
         rd_start     <= 1'b0;
         cnvst        <= 1'b0;
         cs_n         <= 1'b1;
         result       <= '0;
         result_valid <= 1'b0;
         overrun      <= 1'b0;
      end else begin
         cnvst        <= 1'b0;
         rd_start     <= 1'b0;
         result_valid <= 1'b0;
         overrun      <= 1'b0;
         case (state)
            ST_IDLE: if (go) begin
               cnvst    <= 1'b1;
               early_q  <= read_early;
               serial_q <= use_serial;
               rise_q   <= sample_rise;
               state    <= ST_START;
            end
            ST_START: state <= ST_WAIT_RISE;
            ST_WAIT_RISE: if (busy) begin
               if (early_q) begin
                  cs_n     <= 1'b0;
                  rd_start <= 1'b1;
                  state    <= ST_READ;
               end else begin
                  state <= ST_WAIT_FALL;
               end
            end
            ST_WAIT_FALL: if (!busy) begin
               cs_n     <= 1'b0;
               rd_start <= 1'b1;
               state    <= ST_READ;
            end
            ST_READ: begin
               if (rdr_done) begin
                  result       <= serial_q ? s_word : p_word;
                  result_valid <= 1'b1;
                  cs_n         <= 1'b1;
                  state        <= early_q ? ST_DRAIN : ST_IDLE;
               end else if (deadline_hit) begin
                  overrun <= 1'b1;
                  cs_n    <= 1'b1;
                  state   <= ST_DRAIN;
               end
            end
            ST_DRAIN: if (!busy) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cnvst,
   input logic cs_n,
   input logic rd_n,
   input logic sclk,
   input logic result_valid,
   input logic overrun,
   input logic deadline_hit
);
   // R2
   a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
      cnvst |=> !cnvst);
   // R3
   a_r3_read_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !cs_n);
   // R4
   a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   // R9
   a_r9_no_edge_past_deadline: assert property (@(posedge clk) disable iff (!rst_n)
      deadline_hit |=> (!$rose(sclk) && !$fell(rd_n)));
   // R10
   a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   // R10
   a_r10_valid_not_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      !(result_valid && overrun));
   // R11
   a_r11_no_start_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !cnvst);
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .cs_n(cs_n), .rd_n(rd_n),
   .sclk(sclk), .result_valid(result_valid), .overrun(overrun),
   .deadline_hit(deadline_hit)
);

// File: tb/sim_adc_readout_ctrl.sv
`timescale 1ns/1ps
module sim_adc_readout_ctrl;
   localparam int CONV = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0, use_serial = 1'b0, read_early = 1'b0, sample_rise = 1'b0;
   logic [7:0]  sclk_div = 8'd0;
   logic [15:0] conv_len = 16'(CONV);
   logic cnvst, cs_n, rd_n, byte_lo, sclk, result_valid, overrun;
   logic [17:0] result;

   always #2.5 clk = ~clk;

   // converter model
   logic        busy_m;
   logic [17:0] dout_m, nxt_m;
   int          pend, ccnt, sidx;
   wire  [7:0]  pbus = (!cs_n && !rd_n) ? (byte_lo ? dout_m[9:2] : dout_m[17:10]) : 8'bz;
   wire         sd   = (sidx < 18) ? dout_m[17 - sidx] : 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         busy_m <= 1'b0; pend <= 0; ccnt <= 0; dout_m <= 18'h1F0E1;
      end else begin
         if (cnvst && !busy_m && pend == 0) pend <= 2;
         if (pend != 0) pend <= pend - 1;
         if (pend == 1) begin busy_m <= 1'b1; ccnt <= CONV; end
         if (busy_m) begin
            ccnt <= ccnt - 1;
            if (ccnt == 1) begin busy_m <= 1'b0; dout_m <= nxt_m; end
         end
      end
   end

   always @(negedge sclk or posedge cs_n) begin
      if (cs_n) sidx <= 0;
      else      sidx <= sidx + 1;
   end

   int rises = 0, r3_bad = 0;
   always @(posedge sclk) rises <= rises + 1;
   always @(negedge clk) if (rst_n && !rd_n && cs_n) r3_bad++;

   adc_readout_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .go(go), .use_serial(use_serial),
      .read_early(read_early), .sample_rise(sample_rise), .sclk_div(sclk_div),
      .conv_len(conv_len), .busy(busy_m), .par_data(pbus), .sdata(sd),
      .cnvst(cnvst), .cs_n(cs_n), .rd_n(rd_n), .byte_lo(byte_lo), .sclk(sclk),
      .result(result), .result_valid(result_valid), .overrun(overrun)
   );

   int checks = 0, errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [17:0] expect_word(input bit ser, input logic [17:0] src);
      return ser ? src : {src[17:2], 2'b00};
   endfunction

   task automatic run_one(input bit ser, input bit early, input bit srise,
                          input int div, input logic [17:0] smp, input bit exp_ovr);
      logic [17:0] expv, val;
      bit got_v, got_o;
      string tag;
      @(negedge clk);
      use_serial = ser; read_early = early; sample_rise = srise;
      sclk_div = 8'(div); nxt_m = smp;
      expv = expect_word(ser, early ? dout_m : smp);
      tag = !ser ? (early ? "R6/R8" : "R6/R7")
                 : (early ? (srise ? "R5/R8" : "R4/R8") : (srise ? "R5/R7" : "R4/R7"));
      rises = 0;
      go = 1'b1;
      @(negedge clk);
      check(cnvst == 1'b1, "R2 start pulse", int'(cnvst), 1);
      go = 1'b0;
      @(negedge clk);
      check(cnvst == 1'b0, "R2 start width", int'(cnvst), 0);
      got_v = 0; got_o = 0; val = '0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (result_valid) begin got_v = 1; val = result; break; end
         if (overrun) begin got_o = 1; break; end
      end
      if (exp_ovr) begin
         check(got_o && !got_v, "R9 overrun", int'(got_o), 1);
      end else begin
         check(got_v, "R10 valid seen", int'(got_v), 1);
         check(val == expv, tag, int'(val), int'(expv));
         if (ser) check(rises == 18, "R4 pulse count", rises, 18);
      end
      if (got_v || got_o) begin
         @(negedge clk);
         check(!result_valid && !overrun, "R10 one-cycle strobe",
               int'({result_valid, overrun}), 0);
      end
      for (int i = 0; i < 1000 && (busy_m || !cs_n); i++) @(negedge clk);
      repeat (3) @(negedge clk);
      check(cs_n && rd_n && !sclk, "R3 bus released", int'({cs_n, rd_n, sclk}), 6);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed, nstart, nvalid;
      seed = $urandom(1234);
      nxt_m = 18'h0;
      repeat (5) @(negedge clk);
      check({cnvst, sclk, result_valid, overrun} == 4'b0, "R1 low outputs",
            int'({cnvst, sclk, result_valid, overrun}), 0);
      check(cs_n && rd_n, "R1 high controls", int'({cs_n, rd_n}), 3);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_one(1, 0, 0, 0, 18'h3FFFF, 0);
      run_one(1, 0, 1, 2, 18'h20000, 0);
      run_one(1, 1, 0, 0, 18'h00001, 0);
      run_one(1, 1, 1, 1, 18'h2A5C3, 0);
      run_one(0, 0, 0, 0, 18'h1B7F6, 0);
      run_one(0, 1, 0, 0, 18'h0C0DE, 0);
      run_one(1, 1, 0, 3, 18'h15555, 1);   // R9 deadline missed
      run_one(0, 1, 0, 0, 18'h3F00F, 0);

      // R11: go held high yields one start per completed read
      @(negedge clk);
      use_serial = 0; read_early = 0; nxt_m = 18'h12345;
      nstart = 0; nvalid = 0;
      go = 1'b1;
      for (int i = 0; i < 4000 && nvalid < 2; i++) begin
         @(negedge clk);
         if (cnvst) nstart++;
         if (result_valid) nvalid++;
         if (nvalid == 2) go = 1'b0;
      end
      go = 1'b0;
      check(nstart == 2, "R11 starts per read", nstart, 2);
      for (int i = 0; i < 1000 && (busy_m || !cs_n); i++) @(negedge clk);
      repeat (3) @(negedge clk);

      for (int k = 0; k < 24; k++) begin
         bit ser, early;
         int div;
         ser   = 1'($urandom);
         early = 1'($urandom);
         div   = early ? int'($urandom % 2) : int'($urandom % 3);
         run_one(ser, early, 1'($urandom), div, 18'($urandom), 0);
      end

      check(r3_bad == 0, "R3 strobe without select", r3_bad, 0);
      finish_run();
   end
endmodule